// File: doc/BRIEF.md
# Configuration Register Bank with Atomic Divider Commit

This block is the register file behind a byte-wide register port of a pixel-clock front end. A control agent writes and reads bytes by address. The protocol engine that produces those accesses sits outside this block. The block holds the settings for the clock generator and the clamp timer, and drives them as parallel fields to the timing logic downstream. It also holds a fixed revision byte that software can read.

The 12-bit line-length divider is split over two addresses. A write to the upper byte only loads a shadow register. The value the timing logic sees changes only when the low nibble is written. At that point the whole 12-bit value is committed in one edge, so downstream logic never runs on a half-updated ratio. The effective ratio, the programmed value plus one, is also driven out. A flag marks programmed values below the supported minimum, but such values are stored anyway.

Top module: `cfg_regbank`

## Requirements
- R1: After reset the committed divider is 0x69D (1693) and the shadow byte is 0x69. The VCO range is 2'b01, the pump current code is 3'b001, the phase step is 16 and the clamp offset is 1.
- R2: Address 0x00 reads the REV parameter, with the functional revision in bits 7:4 and the minor revision in bits 3:0. Writes to it change nothing.
- R3: A write to address 0x01 loads the shadow byte, which reads back at 0x01. It leaves the committed divider unchanged.
- R4: A write to address 0x02 sets the committed divider to {shadow, wdata[7:4]} on that clock edge. Address 0x02 reads the committed low nibble in bits 7:4, and bits 3:0 read as zero.
- R5: div_ratio_o always equals the committed divider plus one.
- R6: div_low_o is high exactly when the committed divider is below DIV_MIN (221). Such a value is still stored and driven as written.
- R7: Address 0x03 bits 6:5 hold the VCO range and bits 4:2 hold the pump current code. Bits 7 and 1:0 read as zero.
- R8: Address 0x04 bits 7:3 hold the 5-bit phase step, one step per 1/32 pixel period. Bits 2:0 read as zero.
- R9: Address 0x05 holds the clamp offset in pixel periods. A written zero is stored and driven unchanged.
- R10: Addresses above 0x05 read as zero, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one access per cycle |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| div_val_o | output | 12 | Committed divider value |
| div_ratio_o | output | 13 | Committed divider plus one |
| div_low_o | output | 1 | Committed divider below DIV_MIN |
| vco_range_o | output | 2 | VCO range select |
| pump_cur_o | output | 3 | Charge-pump current code |
| phase_o | output | 5 | Sampling phase step |
| clamp_pos_o | output | 8 | Clamp start offset after sync |

## Verification
The bench builds the block with its default parameters: an 8-bit address, REV = 0x12 and DIV_MIN = 221. Because the address is 8 bits wide, unmapped addresses such as 0x0A and 0xFF can be reached. DIV_MIN at its default lets the bench commit 220 and 221 and check both sides of the low flag. The vectors interleave high-byte and low-nibble writes, so any path that commits the divider on a high-byte write would show up in the next check.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned DIV_W  = 12;
  localparam int unsigned HI_W   = 8;
  localparam int unsigned LO_W   = DIV_W - HI_W;
  localparam logic [DIV_W-1:0] DIV_RST = 12'h69D;

  localparam logic [7:0] A_REV   = 8'h00;
  localparam logic [7:0] A_DIVHI = 8'h01;
  localparam logic [7:0] A_DIVLO = 8'h02;
  localparam logic [7:0] A_CLKG  = 8'h03;
  localparam logic [7:0] A_PHASE = 8'h04;
  localparam logic [7:0] A_CLAMP = 8'h05;

  typedef struct packed {
    logic [1:0] vco;
    logic [2:0] cur;
    logic [4:0] phase;
    logic [7:0] clamp;
  } ctrl_t;
endpackage

// File: rtl/cfg_div_buf.sv
module cfg_div_buf
  import cfg_pkg::*;
#(
  parameter int unsigned DIV_MIN = 221
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hi_we_i,
  input  logic             lo_we_i,
  input  logic [7:0]       wdata_i,
  output logic [HI_W-1:0]  shadow_o,
  output logic [DIV_W-1:0] live_o,
  output logic             low_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= DIV_RST[DIV_W-1:LO_W];
      live_o   <= DIV_RST;
    end else begin
      if (hi_we_i) shadow_o <= wdata_i;
      if (lo_we_i) live_o   <= {shadow_o, wdata_i[7:8-LO_W]};
    end
  end

  assign low_o = (live_o < DIV_W'(DIV_MIN));

  a_r3_live_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_we_i |=> $stable(live_o));
  a_r3_shadow_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i |=> shadow_o == $past(wdata_i));
  a_r4_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_we_i && !hi_we_i) |=> live_o[DIV_W-1:LO_W] == $past(shadow_o));
endmodule

// File: rtl/cfg_ctrl_regs.sv
module cfg_ctrl_regs
  import cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clkg_we_i,
  input  logic       phase_we_i,
  input  logic       clamp_we_i,
  input  logic [7:0] wdata_i,
  output ctrl_t      ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o.vco   <= 2'b01;
      ctrl_o.cur   <= 3'b001;
      ctrl_o.phase <= 5'd16;
      ctrl_o.clamp <= 8'd1;
    end else begin
      if (clkg_we_i) begin
        ctrl_o.vco <= wdata_i[6:5];
        ctrl_o.cur <= wdata_i[4:2];
      end
      if (phase_we_i) ctrl_o.phase <= wdata_i[7:3];
      if (clamp_we_i) ctrl_o.clamp <= wdata_i;
    end
  end

  a_r7_clkg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clkg_we_i |=> $stable(ctrl_o.vco) && $stable(ctrl_o.cur));
  a_r8_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_we_i |=> $stable(ctrl_o.phase));
  a_r9_clamp_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_we_i |=> ctrl_o.clamp == $past(wdata_i));
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [7:0]  REV    = 8'h12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HI_W-1:0]   shadow_i,
  input  logic [DIV_W-1:0]  live_i,
  input  ctrl_t             ctrl_i,
  output logic [7:0]        rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_REV):   rdata_o = REV;
      ADDR_W'(A_DIVHI): rdata_o = shadow_i;
      ADDR_W'(A_DIVLO): rdata_o = {live_i[LO_W-1:0], {(8-LO_W){1'b0}}};
      ADDR_W'(A_CLKG):  rdata_o = {1'b0, ctrl_i.vco, ctrl_i.cur, 2'b00};
      ADDR_W'(A_PHASE): rdata_o = {ctrl_i.phase, 3'b000};
      ADDR_W'(A_CLAMP): rdata_o = ctrl_i.clamp;
      default:          rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [7:0]  REV     = 8'h12,
  parameter int unsigned DIV_MIN = 221
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  output logic [11:0]       div_val_o,
  output logic [12:0]       div_ratio_o,
  output logic              div_low_o,
  output logic [1:0]        vco_range_o,
  output logic [2:0]        pump_cur_o,
  output logic [4:0]        phase_o,
  output logic [7:0]        clamp_pos_o
);
  logic [HI_W-1:0] shadow;
  ctrl_t           ctrl;

  wire hit_hi    = we_i && (addr_i == ADDR_W'(A_DIVHI));
  wire hit_lo    = we_i && (addr_i == ADDR_W'(A_DIVLO));
  wire hit_clkg  = we_i && (addr_i == ADDR_W'(A_CLKG));
  wire hit_phase = we_i && (addr_i == ADDR_W'(A_PHASE));
  wire hit_clamp = we_i && (addr_i == ADDR_W'(A_CLAMP));

  cfg_div_buf #(.DIV_MIN(DIV_MIN)) u_div (
    .clk_i, .rst_ni, .hi_we_i(hit_hi), .lo_we_i(hit_lo), .wdata_i,
    .shadow_o(shadow), .live_o(div_val_o), .low_o(div_low_o)
  );

  cfg_ctrl_regs u_ctrl (
    .clk_i, .rst_ni, .clkg_we_i(hit_clkg), .phase_we_i(hit_phase),
    .clamp_we_i(hit_clamp), .wdata_i, .ctrl_o(ctrl)
  );

  cfg_rd_mux #(.ADDR_W(ADDR_W), .REV(REV)) u_rd (
    .addr_i, .shadow_i(shadow), .live_i(div_val_o), .ctrl_i(ctrl), .rdata_o
  );

  assign div_ratio_o = {1'b0, div_val_o} + 13'd1;
  assign vco_range_o = ctrl.vco;
  assign pump_cur_o  = ctrl.cur;
  assign phase_o     = ctrl.phase;
  assign clamp_pos_o = ctrl.clamp;

  a_r2_rev_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(A_REV)) |=> $stable(div_val_o) && $stable(clamp_pos_o));
  a_r5_ratio_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(div_val_o) |-> $changed(div_ratio_o));
endmodule

// File: tb/test_cfg_regbank.sv
module test_cfg_regbank;
  logic clk = 0, rst_ni = 0, we = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic [11:0] div_val;
  logic [12:0] div_ratio;
  logic div_low;
  logic [1:0] vco;
  logic [2:0] cur;
  logic [4:0] phase;
  logic [7:0] clamp;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  cfg_regbank i_cfg_regbank (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .div_val_o(div_val), .div_ratio_o(div_ratio),
    .div_low_o(div_low), .vco_range_o(vco), .pump_cur_o(cur),
    .phase_o(phase), .clamp_pos_o(clamp)
  );

  // addr, wdata, expected committed divider, expected readback of addr
  localparam logic [35:0] VEC [8] = '{
    {8'h01, 8'h12, 12'h69D, 8'h12},
    {8'h02, 8'h30, 12'h123, 8'h30},
    {8'h01, 8'hFF, 12'h123, 8'hFF},
    {8'h02, 8'hF5, 12'hFFF, 8'hF0},
    {8'h01, 8'h0D, 12'hFFF, 8'h0D},
    {8'h02, 8'hC0, 12'h0DC, 8'hC0},
    {8'h02, 8'hD0, 12'h0DD, 8'hD0},
    {8'h00, 8'hAA, 12'h0DD, 8'h12}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 div", div_val, 12'h69D);
    chk("R1 vco", vco, 2'b01);
    chk("R1 cur", cur, 3'b001);
    chk("R1 phase", phase, 16);
    chk("R1 clamp", clamp, 1);
    rd_chk("R1 shadow", 8'h01, 8'h69);
    rd_chk("R4 lo readback", 8'h02, 8'hD0);
    rd_chk("R2 rev", 8'h00, 8'h12);
    rd_chk("R7 reset readback", 8'h03, 8'h24);
    rd_chk("R8 reset readback", 8'h04, 8'h80);

    // R3 R4 R5 R6 divider vectors
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][35:28], VEC[i][27:20]);
      chk("R3/R4 div", div_val, VEC[i][19:8]);
      chk("R5 ratio", div_ratio, VEC[i][19:8] + 1);
      chk("R6 low flag", div_low, VEC[i][19:8] < 221);
      rd_chk("R3/R4 readback", VEC[i][35:28], VEC[i][7:0]);
    end

    // R7 clock generator fields
    wr(8'h03, 8'hFF);
    chk("R7 vco", vco, 2'b11);
    chk("R7 cur", cur, 3'b111);
    rd_chk("R7 readback", 8'h03, 8'h7C);
    wr(8'h03, 8'h48);
    chk("R7 vco", vco, 2'b10);
    chk("R7 cur", cur, 3'b010);

    // R8 phase
    wr(8'h04, 8'h3F);
    chk("R8 phase", phase, 7);
    rd_chk("R8 readback", 8'h04, 8'h38);

    // R9 clamp including zero
    wr(8'h05, 8'hFF);
    chk("R9 clamp max", clamp, 255);
    wr(8'h05, 8'h00);
    chk("R9 clamp zero", clamp, 0);
    rd_chk("R9 readback", 8'h05, 8'h00);

    // R10 unmapped
    wr(8'h0A, 8'h55);
    wr(8'hFF, 8'hFF);
    rd_chk("R10 read 0A", 8'h0A, 8'h00);
    rd_chk("R10 read FF", 8'hFF, 8'h00);
    chk("R10 div", div_val, 12'h0DD);
    chk("R10 vco", vco, 2'b10);
    chk("R10 phase", phase, 7);
    chk("R10 clamp", clamp, 0);
    rd_chk("R10 shadow", 8'h01, 8'h0D);

    // R1 reset mid-run restores defaults
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    chk("R1 div after reset", div_val, 12'h69D);
    chk("R1 clamp after reset", clamp, 1);
    finish_run();
  end
endmodule